// File: doc/BRIEF.md
# Split-Stage Four-Tap FIR Filter

This block is a four-tap finite impulse response filter for signed L-bit samples. Its four signed coefficients are fixed by parameters. It accepts one sample per clock under a valid flag and returns one exact filter result for every sample it accepts. The taps are numbered from the newest sample (tap 0) to the oldest (tap 3). The result is a full-precision sum of products, 2L+2 bits wide, so it never wraps.

The design cuts each multiply and each add roughly at its midpoint and places one register rank at that cut. In the first stage, the partial products of taps 0 and 1 are compressed together into one redundant sum/carry pair. Taps 2 and 3 get the same treatment. This merges the early multiply and early add work. The four redundant vectors are registered. In the second stage, one four-operand adder reduces them to a single value: two carry-save layers followed by a carry-propagate add. That value goes to the output register. The longest path is therefore about half a multiply plus a few full-adder delays, not a multiply followed by an adder tree.

The filter history moves only on accepted samples. A gap in the input stream stretches time without changing the arithmetic.

Top module: `fir4_split_retimed`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted and after it is released, out_valid is 0 and out_data is 0. All three stored history samples start at zero, so the first results after reset use 0 for samples not yet received.
- R2: For the n-th accepted sample, out_data equals C0*x[n] + C1*x[n-1] + C2*x[n-2] + C3*x[n-3]. Here x is the stream of accepted samples, each read as L-bit two's complement, and C0..C3 are the signed coefficient parameters.
- R3: out_data is a 2L+2-bit two's-complement value and is exact for every sample and coefficient value, including the most negative L-bit value.
- R4: A sample presented with in_valid high at clock edge k gives out_valid high after edge k+1, for exactly one cycle per accepted sample.
- R5: Cycles with in_valid low do not move the history. Results depend only on the sequence of accepted samples, whatever the gaps between them.
- R6: In a cycle with no new result, out_valid is 0 and out_data keeps its previous value.
- R7: Samples accepted on consecutive clocks give results on consecutive clocks, at a rate of one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | L | Signed input sample |
| out_valid | output | 1 | High for one cycle per result |
| out_data | output | 2L+2 | Signed filter result |

## Verification
The bench sweeps every L-bit sample value through the filter back to back, so each value reaches each tap. A misordered tap, a wrong sign on the last partial-product row, or a lost correction bit therefore gives wrong sums on that sweep. Runs of the most negative and most positive samples push the result toward its largest magnitude. A datapath that is one bit short, or that sign-extends wrongly, would wrap there. Streams with irregular gaps check that idle cycles neither shift the history nor disturb the held output. A design that advanced its taps every clock would give different sums after each gap. A wrong valid delay shows up as results arriving one cycle early or late.

// File: rtl/fir4_pkg.sv
package fir4_pkg;
  localparam int NTAPS = 4;

  // width of a sum of NTAPS products of two l-bit signed operands
  function automatic int sum_width(input int l);
    return 2 * l + 2;
  endfunction
endpackage

// File: rtl/fir4_csa.sv
module fir4_csa #(
  parameter int W = 18
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] s,
  output logic [W-1:0] co
);
  // 3:2 compression, carry vector pre-shifted one place
  assign s  = a ^ b ^ c;
  assign co = {((a[W-2:0] & b[W-2:0]) | (a[W-2:0] & c[W-2:0]) | (b[W-2:0] & c[W-2:0])), 1'b0};
endmodule

// File: rtl/fir4_tap_line.sv
module fir4_tap_line #(
  parameter int L     = 8,
  parameter int DEPTH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift_en,
  input  logic [L-1:0]            din,
  output logic [DEPTH-1:0][L-1:0] taps
);
  for (genvar d = 0; d < DEPTH; d++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        taps[d] <= '0;
      else if (shift_en) taps[d] <= (d == 0) ? din : taps[(d == 0) ? 0 : d-1];
    end
  end
endmodule

// File: rtl/fir4_pair_reduce.sv
module fir4_pair_reduce #(
  parameter int L = 8,
  parameter int W = 18
) (
  input  logic [L-1:0] coef_a,
  input  logic [L-1:0] coef_b,
  input  logic [L-1:0] samp_a,
  input  logic [L-1:0] samp_b,
  output logic [W-1:0] sum_v,
  output logic [W-1:0] carry_v
);
  localparam int NOPS = 2 * L + 1;

  // one partial-product row; the sign row is negated as ~x, its +1 goes in the correction word
  function automatic logic [W-1:0] pp_row(input logic [L-1:0] mc, input logic bit_v, input int idx);
    logic [W-1:0] ext;
    ext = {{(W-L){mc[L-1]}}, mc};
    if (!bit_v)        return '0;
    if (idx == L - 1)  return ~(ext << idx);
    return ext << idx;
  endfunction

  logic [W-1:0] ops  [NOPS];
  logic [W-1:0] s_ch [NOPS];
  logic [W-1:0] c_ch [NOPS];

  always_comb begin
    for (int i = 0; i < L; i++) begin
      ops[i]     = pp_row(coef_a, samp_a[i], i);
      ops[L + i] = pp_row(coef_b, samp_b[i], i);
    end
    ops[2*L] = W'(samp_a[L-1]) + W'(samp_b[L-1]);
  end

  assign s_ch[0] = ops[0];
  assign c_ch[0] = '0;

  // both taps' rows fold into one redundant pair
  for (genvar k = 1; k < NOPS; k++) begin : g_fold
    fir4_csa #(.W(W)) u_csa (
      .a (s_ch[k-1]),
      .b (c_ch[k-1]),
      .c (ops[k]),
      .s (s_ch[k]),
      .co(c_ch[k])
    );
  end

  assign sum_v   = s_ch[NOPS-1];
  assign carry_v = c_ch[NOPS-1];
endmodule

// File: rtl/fir4_quad_add.sv
module fir4_quad_add #(
  parameter int W = 18
) (
  input  logic [W-1:0] op0,
  input  logic [W-1:0] op1,
  input  logic [W-1:0] op2,
  input  logic [W-1:0] op3,
  output logic [W-1:0] total
);
  logic [W-1:0] s1, c1, s2, c2;

  fir4_csa #(.W(W)) u_l1 (.a(op0), .b(op1), .c(op2), .s(s1), .co(c1));
  fir4_csa #(.W(W)) u_l2 (.a(s1),  .b(c1),  .c(op3), .s(s2), .co(c2));

  assign total = s2 + c2;
endmodule

// File: rtl/fir4_split_retimed.sv
module fir4_split_retimed #(
  parameter int L  = 8,
  parameter int C0 = -128,
  parameter int C1 = 127,
  parameter int C2 = -77,
  parameter int C3 = -128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [L-1:0]                  in_sample,
  output logic                          out_valid,
  output logic [fir4_pkg::sum_width(L)-1:0] out_data
);
  localparam int W     = fir4_pkg::sum_width(L);
  localparam int NT    = fir4_pkg::NTAPS;
  localparam int NPAIR = NT / 2;

  logic [NT-2:0][L-1:0] hist;
  logic [NT-1:0][L-1:0] xv;
  logic [NT-1:0][L-1:0] kv;
  logic [NPAIR-1:0][W-1:0] pr_s, pr_c;
  logic [NPAIR-1:0][W-1:0] st_s, st_c;
  logic                    st_valid;
  logic [W-1:0]            quad_sum;

  assign kv[0] = L'(C0);
  assign kv[1] = L'(C1);
  assign kv[2] = L'(C2);
  assign kv[3] = L'(C3);
  assign xv    = {hist, in_sample};

  fir4_tap_line #(.L(L), .DEPTH(NT-1)) u_taps (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(in_sample), .taps(hist)
  );

  // first half: merged multiply front ends and first add, per tap pair
  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    fir4_pair_reduce #(.L(L), .W(W)) u_pair (
      .coef_a (kv[2*g]),   .coef_b (kv[2*g+1]),
      .samp_a (xv[2*g]),   .samp_b (xv[2*g+1]),
      .sum_v  (pr_s[g]),   .carry_v(pr_c[g])
    );
  end

  // feed-forward cut: redundant vectors registered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_s     <= '0;
      st_c     <= '0;
      st_valid <= 1'b0;
    end else begin
      if (in_valid) begin
        st_s <= pr_s;
        st_c <= pr_c;
      end
      st_valid <= in_valid;
    end
  end

  // second half: merged four-operand adder
  fir4_quad_add #(.W(W)) u_quad (
    .op0(st_s[0]), .op1(st_c[0]), .op2(st_s[1]), .op3(st_c[1]), .total(quad_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (st_valid) out_data <= quad_sum;
      out_valid <= st_valid;
    end
  end

  // ---------------- assertions ----------------
  function automatic logic [W-1:0] sx(input logic [L-1:0] v);
    return {{(W-L){v[L-1]}}, v};
  endfunction

  logic [W-1:0] direct_sum;
  assign direct_sum = sx(kv[0]) * sx(xv[0]) + sx(kv[1]) * sx(xv[1])
                    + sx(kv[2]) * sx(xv[2]) + sx(kv[3]) * sx(xv[3]);

  AST_PAIR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (st_s[0] + st_c[0] + st_s[1] + st_c[1]) == $past(direct_sum)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> out_data == $past(st_s[0] + st_c[0] + st_s[1] + st_c[1])); // R3

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 (!out_valid && $stable(out_data))); // R6
endmodule

// File: tb/test_fir4_split_retimed.sv
module test_fir4_split_retimed;
  localparam int L  = 8;
  localparam int W  = 2 * L + 2;
  localparam int K0 = -128;
  localparam int K1 = 127;
  localparam int K2 = -77;
  localparam int K3 = -128;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [L-1:0] in_sample;
  logic         out_valid;
  logic [W-1:0] out_data;

  always #5 clk = ~clk;

  fir4_split_retimed #(.L(L), .C0(K0), .C1(K1), .C2(K2), .C3(K3)) i_fir4_split_retimed (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_data(out_data)
  );

  int    total = 0;
  int    bad   = 0;
  int    hist [4];
  bit    vp   [2];
  int    ep   [2];
  int    last_out = 0;
  string tag = "R2";
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: compare outputs, then drive the next input
  task automatic step(input bit v, input int s);
    int got;
    @(negedge clk);
    got = $signed(out_data);
    check("R4", int'(out_valid), int'(vp[1]));
    if (vp[1]) begin
      check(tag, got, ep[1]);
      last_out = got;
    end else begin
      check("R6", got, last_out);
    end
    vp[1] = vp[0];
    ep[1] = ep[0];
    vp[0] = v;
    if (v) begin
      hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = s;
      ep[0] = K0*hist[0] + K1*hist[1] + K2*hist[2] + K3*hist[3];
    end
    in_valid  = v;
    in_sample = s[L-1:0];
  endtask

  function automatic int rnd_sample(input logic [15:0] r);
    return int'($signed(r[L-1:0]));
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) hist[i] = 0;
    vp[0] = 0; vp[1] = 0; ep[0] = 0; ep[1] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    repeat (3) @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", $signed(out_data), 0);
    rst_n = 1'b1;

    // first results mix zero history with new samples
    tag = "R1";
    step(1, 100); step(1, -3); step(1, 77);
    // full sweep of every sample value, back to back
    tag = "R7";
    for (int s = -(1 << (L-1)); s < (1 << (L-1)); s++) step(1, s);
    // extremes toward largest magnitude
    tag = "R3";
    for (int i = 0; i < 8; i++) step(1, -128);
    for (int i = 0; i < 8; i++) step(1, 127);
    for (int i = 0; i < 8; i++) step(1, (i % 2) ? 127 : -128);
    step(1, -128); step(1, 127); step(1, -128); step(1, -128);
    // irregular gaps
    tag = "R5";
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[9] & lfsr[3], rnd_sample(lfsr));
    end
    // dense random stream
    tag = "R2";
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1, rnd_sample(lfsr));
    end
    // drain and idle
    for (int i = 0; i < 6; i++) step(0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule